// File: doc/BRIEF.md
# Branch-Steered Fetch Bank Selector

This controller sits in front of an instruction store split into several small banks and decides, each time a branch resolves, where the next run of fetches is served from. It keeps a small direct-mapped branch table. Each entry is tagged with a branch address and holds two optional bank numbers: one for the basic block at the taken target and one for the block at the fall-through target. Either number may be marked absent, which means that block is held in no bank.

When a branch resolves, the controller reads the entry for that branch and picks the field that matches the outcome. If the field holds a bank number, that bank serves the following fetches. If the field is absent, the table misses, or the branch is indirect, every bank is bypassed and fetches go straight to main memory. The choice stays in force for all sequential fetches until the next branch resolves. The block drives a per-bank enable, a bank select and a cache-or-memory select. Table entries are loaded through a configuration write port.

Top module: `fetch_steer`

## Requirements
- R1: After reset, the selection is main memory (`mem_sel_o` = 1) and no bank enable is high.
- R2: A configuration write stores an entry at index `cfg_pc_i[5:2]` with tag `cfg_pc_i[31:6]`. A later resolved branch at the same address uses the stored bank fields from the cycle after it resolves.
- R3: A resolved direct branch that hits the table selects the taken-field bank when `br_taken_i` = 1 and the fall-through-field bank when `br_taken_i` = 0. It then drives `mem_sel_o` = 0 and `bank_sel_o` = that bank number.
- R4: When the chosen field is marked absent (its valid input was 0 at write time), the selection becomes main memory and no bank enable is raised.
- R5: A resolved branch whose entry is empty, or whose tag differs, selects main memory.
- R6: A resolved branch with `br_indirect_i` = 1 selects main memory, whatever the table holds for its address.
- R7: The selection (`mem_sel_o`, and `bank_sel_o` while a bank is selected) does not change in any cycle without a resolved branch, however many fetches are made.
- R8: `bank_en_o` has bit b high only when `fetch_req_i` = 1, a bank is selected and b equals `bank_sel_o`. `mem_req_o` is high only when `fetch_req_i` = 1 and memory is selected.
- R9: Two addresses with equal bits [5:2] share one entry. A later write replaces the earlier one, and the earlier address then misses.
- R10: When a configuration write and a branch resolve in the same cycle at the same index, the lookup uses the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_pc_i | input | 32 | Branch address of the entry being written |
| cfg_tk_vld_i | input | 1 | Taken-target bank field present |
| cfg_tk_bank_i | input | 2 | Bank holding the taken-target block |
| cfg_nt_vld_i | input | 1 | Fall-through bank field present |
| cfg_nt_bank_i | input | 2 | Bank holding the fall-through block |
| br_vld_i | input | 1 | A branch resolves this cycle |
| br_pc_i | input | 32 | Address of the resolving branch |
| br_taken_i | input | 1 | Outcome of the branch, 1 = taken |
| br_indirect_i | input | 1 | Branch target is computed at run time |
| fetch_req_i | input | 1 | Sequential fetch request this cycle |
| bank_en_o | output | 4 | Per-bank access enable |
| bank_sel_o | output | 2 | Currently selected bank number |
| mem_sel_o | output | 1 | 1 = fetches go to main memory, 0 = to the selected bank |
| mem_req_o | output | 1 | Fetch forwarded to main memory |

## Verification
The bench aims at aliasing branch addresses that share an index but differ in tag. A design that compared too few tag bits would steer such a branch into a bank that holds another block. It drives a write and a resolve at the same index in one cycle; a design that forwarded the new entry would pick a bank one branch too early. Indirect branches are sent at addresses with fully loaded entries, and absent fields are mixed with present ones. Either mistake would leave a bank enabled while memory should serve the fetch. Long runs without a branch and with fetch requests toggling expose a selection that drifts or enables that stay high with no request.

// File: rtl/fsteer_pkg.sv
package fsteer_pkg;
  typedef enum logic {
    SRC_MEM  = 1'b0,
    SRC_BANK = 1'b1
  } fetch_src_e;

  localparam int DEF_NUM_BANKS = 4;
  localparam int DEF_TBL_DEPTH = 16;
  localparam int DEF_PC_W      = 32;
endpackage

// File: rtl/fsteer_table.sv
module fsteer_table #(
  parameter int NUM_BANKS = fsteer_pkg::DEF_NUM_BANKS,
  parameter int DEPTH     = fsteer_pkg::DEF_TBL_DEPTH,
  parameter int PC_W      = fsteer_pkg::DEF_PC_W,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int TAG_W    = PC_W - IDX_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PC_W-1:0]   wr_pc_i,
  input  logic              wr_tk_vld_i,
  input  logic [BANK_W-1:0] wr_tk_bank_i,
  input  logic              wr_nt_vld_i,
  input  logic [BANK_W-1:0] wr_nt_bank_i,
  input  logic [PC_W-1:0]   rd_pc_i,
  output logic              rd_hit_o,
  output logic              rd_tk_vld_o,
  output logic [BANK_W-1:0] rd_tk_bank_o,
  output logic              rd_nt_vld_o,
  output logic [BANK_W-1:0] rd_nt_bank_o
);
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [TAG_W-1:0]  wr_tag, rd_tag;
  logic              unused_lsb;

  logic              vld_q    [DEPTH];
  logic [TAG_W-1:0]  tag_q    [DEPTH];
  logic              tk_vld_q [DEPTH];
  logic [BANK_W-1:0] tk_bank_q[DEPTH];
  logic              nt_vld_q [DEPTH];
  logic [BANK_W-1:0] nt_bank_q[DEPTH];

  // word-aligned branch addresses: bits [1:0] carry no information
  assign wr_idx     = wr_pc_i[IDX_W+1:2];
  assign wr_tag     = wr_pc_i[PC_W-1:IDX_W+2];
  assign rd_idx     = rd_pc_i[IDX_W+1:2];
  assign rd_tag     = rd_pc_i[PC_W-1:IDX_W+2];
  assign unused_lsb = ^{wr_pc_i[1:0], rd_pc_i[1:0]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]     <= 1'b0;
        tag_q[g]     <= '0;
        tk_vld_q[g]  <= 1'b0;
        tk_bank_q[g] <= '0;
        nt_vld_q[g]  <= 1'b0;
        nt_bank_q[g] <= '0;
      end else if (wr_en_i && (wr_idx == IDX_W'(g))) begin
        vld_q[g]     <= 1'b1;
        tag_q[g]     <= wr_tag;
        tk_vld_q[g]  <= wr_tk_vld_i;
        tk_bank_q[g] <= wr_tk_bank_i;
        nt_vld_q[g]  <= wr_nt_vld_i;
        nt_bank_q[g] <= wr_nt_bank_i;
      end
    end
  end

  // read sees pre-write contents in a same-cycle write
  always_comb begin
    rd_hit_o     = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_tk_vld_o  = tk_vld_q[rd_idx];
    rd_tk_bank_o = tk_bank_q[rd_idx];
    rd_nt_vld_o  = nt_vld_q[rd_idx];
    rd_nt_bank_o = nt_bank_q[rd_idx];
  end

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))));

  p_write_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (tk_vld_q[$past(wr_idx)] == $past(wr_tk_vld_i))
             && (nt_vld_q[$past(wr_idx)] == $past(wr_nt_vld_i)));
endmodule

// File: rtl/fsteer_sel.sv
module fsteer_sel #(
  parameter int NUM_BANKS = fsteer_pkg::DEF_NUM_BANKS,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 br_vld_i,
  input  logic                 br_taken_i,
  input  logic                 br_indirect_i,
  input  logic                 hit_i,
  input  logic                 tk_vld_i,
  input  logic [BANK_W-1:0]    tk_bank_i,
  input  logic                 nt_vld_i,
  input  logic [BANK_W-1:0]    nt_bank_i,
  input  logic                 fetch_req_i,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic [BANK_W-1:0]    bank_sel_o,
  output logic                 mem_sel_o,
  output logic                 mem_req_o
);
  import fsteer_pkg::*;

  fetch_src_e        src_q, src_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              fld_vld;
  logic [BANK_W-1:0] fld_bank;

  always_comb begin
    fld_vld  = br_taken_i ? tk_vld_i  : nt_vld_i;
    fld_bank = br_taken_i ? tk_bank_i : nt_bank_i;
    src_d    = src_q;
    bank_d   = bank_q;
    if (br_vld_i) begin
      if (!br_indirect_i && hit_i && fld_vld) begin
        src_d  = SRC_BANK;
        bank_d = fld_bank;
      end else begin
        src_d  = SRC_MEM;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_MEM;
      bank_q <= '0;
    end else begin
      src_q  <= src_d;
      bank_q <= bank_d;
    end
  end

  assign mem_sel_o  = (src_q == SRC_MEM);
  assign bank_sel_o = bank_q;
  assign mem_req_o  = fetch_req_i && (src_q == SRC_MEM);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
    assign bank_en_o[b] = fetch_req_i && (src_q == SRC_BANK) && (bank_q == BANK_W'(b));
  end

  p_en_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_en_o));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i |-> (bank_en_o == '0) && !mem_req_o);

  p_mem_blocks_banks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o |-> (bank_en_o == '0));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_vld_i |=> $stable(mem_sel_o) && $stable(bank_sel_o));

  p_indirect_mem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_vld_i && br_indirect_i) |=> mem_sel_o);

  p_miss_mem_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_vld_i && !hit_i) |=> mem_sel_o);
endmodule

// File: rtl/fetch_steer.sv
module fetch_steer #(
  parameter int NUM_BANKS = fsteer_pkg::DEF_NUM_BANKS,
  parameter int TBL_DEPTH = fsteer_pkg::DEF_TBL_DEPTH,
  parameter int PC_W      = fsteer_pkg::DEF_PC_W,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [PC_W-1:0]      cfg_pc_i,
  input  logic                 cfg_tk_vld_i,
  input  logic [BANK_W-1:0]    cfg_tk_bank_i,
  input  logic                 cfg_nt_vld_i,
  input  logic [BANK_W-1:0]    cfg_nt_bank_i,
  input  logic                 br_vld_i,
  input  logic [PC_W-1:0]      br_pc_i,
  input  logic                 br_taken_i,
  input  logic                 br_indirect_i,
  input  logic                 fetch_req_i,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic [BANK_W-1:0]    bank_sel_o,
  output logic                 mem_sel_o,
  output logic                 mem_req_o
);
  logic              hit;
  logic              tk_vld, nt_vld;
  logic [BANK_W-1:0] tk_bank, nt_bank;

  fsteer_table #(
    .NUM_BANKS(NUM_BANKS),
    .DEPTH    (TBL_DEPTH),
    .PC_W     (PC_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cfg_we_i),
    .wr_pc_i     (cfg_pc_i),
    .wr_tk_vld_i (cfg_tk_vld_i),
    .wr_tk_bank_i(cfg_tk_bank_i),
    .wr_nt_vld_i (cfg_nt_vld_i),
    .wr_nt_bank_i(cfg_nt_bank_i),
    .rd_pc_i     (br_pc_i),
    .rd_hit_o    (hit),
    .rd_tk_vld_o (tk_vld),
    .rd_tk_bank_o(tk_bank),
    .rd_nt_vld_o (nt_vld),
    .rd_nt_bank_o(nt_bank)
  );

  fsteer_sel #(
    .NUM_BANKS(NUM_BANKS)
  ) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .br_vld_i     (br_vld_i),
    .br_taken_i   (br_taken_i),
    .br_indirect_i(br_indirect_i),
    .hit_i        (hit),
    .tk_vld_i     (tk_vld),
    .tk_bank_i    (tk_bank),
    .nt_vld_i     (nt_vld),
    .nt_bank_i    (nt_bank),
    .fetch_req_i  (fetch_req_i),
    .bank_en_o    (bank_en_o),
    .bank_sel_o   (bank_sel_o),
    .mem_sel_o    (mem_sel_o),
    .mem_req_o    (mem_req_o)
  );

  p_steer_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_vld_i && !br_indirect_i && hit && br_taken_i && tk_vld)
      |=> (!mem_sel_o && (bank_sel_o == $past(tk_bank))));
endmodule

// File: tb/fetch_steer_test.sv
`timescale 1ns/1ps
module fetch_steer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [31:0] cfg_pc = '0;
  logic       cfg_tv = 1'b0;
  logic [1:0] cfg_tb = '0;
  logic       cfg_nv = 1'b0;
  logic [1:0] cfg_nb = '0;
  logic       br_vld = 1'b0;
  logic [31:0] br_pc = '0;
  logic       br_tk = 1'b0;
  logic       br_ind = 1'b0;
  logic       fetch = 1'b0;
  logic [3:0] bank_en;
  logic [1:0] bank_sel;
  logic       mem_sel;
  logic       mem_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the table and the selection
  bit        m_vld [16];
  bit [25:0] m_tag [16];
  bit        m_tv  [16];
  bit [1:0]  m_tb  [16];
  bit        m_nv  [16];
  bit [1:0]  m_nb  [16];
  bit        m_mem = 1'b1;
  bit [1:0]  m_bank = '0;
  string     m_why = "R1";

  always #5 clk = ~clk;

  fetch_steer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_pc_i(cfg_pc),
    .cfg_tk_vld_i(cfg_tv), .cfg_tk_bank_i(cfg_tb),
    .cfg_nt_vld_i(cfg_nv), .cfg_nt_bank_i(cfg_nb),
    .br_vld_i(br_vld), .br_pc_i(br_pc), .br_taken_i(br_tk), .br_indirect_i(br_ind),
    .fetch_req_i(fetch),
    .bank_en_o(bank_en), .bank_sel_o(bank_sel), .mem_sel_o(mem_sel), .mem_req_o(mem_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit [3:0] exp_en(input bit f, input bit mem, input bit [1:0] b);
    return (f && !mem) ? (4'b1 << b) : 4'b0;
  endfunction

  task automatic check_outputs();
    chk(mem_sel == m_mem, m_why, mem_sel, m_mem);
    chk(bank_en == exp_en(fetch, m_mem, m_bank), "R8 enable", bank_en, exp_en(fetch, m_mem, m_bank));
    chk(mem_req == (fetch && m_mem), "R8 memreq", mem_req, fetch && m_mem);
    if (!m_mem) chk(bank_sel == m_bank, m_why, bank_sel, m_bank);
  endtask

  // model update for the cycle whose inputs are applied
  task automatic model_edge();
    int  i;
    bit  hit;
    if (br_vld) begin
      i   = int'(br_pc[5:2]);
      hit = m_vld[i] && (m_tag[i] == br_pc[31:6]);
      if (br_ind) begin
        m_mem = 1'b1; m_why = "R6";
      end else if (!hit) begin
        m_mem = 1'b1; m_why = "R5";
      end else if (br_tk ? m_tv[i] : m_nv[i]) begin
        m_mem = 1'b0; m_bank = br_tk ? m_tb[i] : m_nb[i]; m_why = "R3";
      end else begin
        m_mem = 1'b1; m_why = "R4";
      end
    end else begin
      m_why = "R7";
    end
    if (cfg_we) begin
      i = int'(cfg_pc[5:2]);
      m_vld[i] = 1'b1; m_tag[i] = cfg_pc[31:6];
      m_tv[i] = cfg_tv; m_tb[i] = cfg_tb; m_nv[i] = cfg_nv; m_nb[i] = cfg_nb;
    end
  endtask

  // drive one cycle at the falling edge, check, advance
  task automatic step(input bit we, input logic [31:0] wpc, input bit tv, input bit [1:0] tb,
                      input bit nv, input bit [1:0] nb, input bit bv, input logic [31:0] bpc,
                      input bit tk, input bit ind, input bit f);
    cfg_we = we; cfg_pc = wpc; cfg_tv = tv; cfg_tb = tb; cfg_nv = nv; cfg_nb = nb;
    br_vld = bv; br_pc = bpc; br_tk = tk; br_ind = ind; fetch = f;
    #1;
    check_outputs();
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] pc, input bit tv, input bit [1:0] tb, input bit nv, input bit [1:0] nb);
    step(1'b1, pc, tv, tb, nv, nb, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic br(input logic [31:0] pc, input bit tk, input bit ind);
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, pc, tk, ind, 1'b1);
  endtask

  function automatic logic [31:0] pool_pc(input int k);
    return 32'h0000_2000 + 32'((k % 3) * 'h40) + 32'(((k * 5) % 16) << 2);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_tv[i] = 0; m_tb[i] = '0; m_nv[i] = 0; m_nb[i] = '0;
    end
    @(negedge clk); @(negedge clk);
    fetch = 1'b1; #1;
    // R1: reset state
    chk(mem_sel == 1'b1, "R1", mem_sel, 1);
    chk(bank_en == 4'b0, "R1", bank_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: load entry, taken then not-taken
    wr(32'h0000_200C, 1'b1, 2'd2, 1'b1, 2'd1);
    br(32'h0000_200C, 1'b1, 1'b0);
    #1 chk(!mem_sel && bank_sel == 2'd2 && bank_en == 4'b0100, "R2 taken", bank_en, 4'b0100);
    br(32'h0000_200C, 1'b0, 1'b0);
    #1 chk(bank_en == 4'b0010, "R3 not-taken", bank_en, 4'b0010);

    // R7 R8: hold with toggling fetch
    for (int k = 0; k < 6; k++)
      step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, k[0]);
    #1 chk(bank_sel == 2'd1 && !mem_sel, "R7 hold", bank_sel, 1);

    // R4: absent taken field
    wr(32'h0000_2010, 1'b0, 2'd3, 1'b1, 2'd3);
    br(32'h0000_2010, 1'b1, 1'b0);
    #1 chk(mem_sel && bank_en == 4'b0, "R4 absent", bank_en, 0);
    br(32'h0000_2010, 1'b0, 1'b0);
    #1 chk(bank_en == 4'b1000, "R4 present", bank_en, 4'b1000);

    // R5: empty entry and aliased tag
    br(32'h0000_2020, 1'b1, 1'b0);
    #1 chk(mem_sel, "R5 empty", mem_sel, 1);
    br(32'h0000_200C, 1'b1, 1'b0);
    br(32'h0000_300C, 1'b1, 1'b0);
    #1 chk(mem_sel, "R5 tag", mem_sel, 1);

    // R6: indirect at loaded address
    br(32'h0000_200C, 1'b1, 1'b0);
    br(32'h0000_200C, 1'b1, 1'b1);
    #1 chk(mem_sel && !bank_en[2], "R6 indirect", mem_sel, 1);

    // R9: alias overwrite
    wr(32'h0000_300C, 1'b1, 2'd0, 1'b1, 2'd0);
    br(32'h0000_200C, 1'b1, 1'b0);
    #1 chk(mem_sel, "R9 evicted", mem_sel, 1);
    br(32'h0000_300C, 1'b1, 1'b0);
    #1 chk(!mem_sel && bank_en == 4'b0001, "R9 new", bank_en, 1);

    // R10: same-cycle write and resolve uses old entry
    step(1'b1, 32'h0000_300C, 1'b1, 2'd3, 1'b1, 2'd3, 1'b1, 32'h0000_300C, 1'b1, 1'b0, 1'b1);
    #1 chk(bank_sel == 2'd0 && !mem_sel, "R10 old", bank_sel, 0);
    br(32'h0000_300C, 1'b1, 1'b0);
    #1 chk(bank_sel == 2'd3, "R10 new", bank_sel, 3);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [31:0] wpc, bpc;
      k   = int'($urandom % 12);
      wpc = pool_pc(k);
      k   = int'($urandom % 13);
      bpc = (k == 12) ? {$urandom, 2'b00} : pool_pc(k);
      step(($urandom % 4) == 0, wpc, ($urandom % 4) != 0, 2'($urandom), ($urandom % 4) != 0,
           2'($urandom), ($urandom % 3) == 0, bpc, 1'($urandom), ($urandom % 8) == 0,
           1'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule